// File: doc/BRIEF.md
# T=0 Card-Side Command Header and Procedure-Byte Controller

This block sits on the card side of a character-oriented T=0 smart-card link, between a byte-level UART and a host that decides what the card answers. It collects the five command-header bytes that the reader sends. It hands the finished header to the host in one strobe, together with the expected data length. After that it relays the host's reply bytes to the reader. Those bytes are a procedure byte, then any outgoing data, then the status word.

Flags on each host byte steer the link direction. With the receive flag, the block turns round to collect the command's data from the reader. It forwards each received byte with a last-byte marker. With the transmit flag, it keeps sending to the reader. A byte carrying both the last and final flags closes the command, and the block goes back to waiting for the next header.

While a reply is pending, a waiting-time counter advances on ETU ticks. If half the programmed waiting time passes with nothing sent, the block sends a NULL byte (0x60) so the reader keeps waiting.

Top module: `t0x_xport_ctrl`

## Requirements
- R1: Received bytes in the idle state and the four following header states are stored in arrival order as CLA, INS, P1, P2, P3. They appear on `hdr_bytes` with CLA in bits 39:32 and P3 in bits 7:0. `hdr_valid` pulses for one cycle, one cycle after the P3 byte is presented.
- R2: After reset the block waits for CLA with `rx_en`=1 and `tx_en`=0. `rx_en` is high while waiting for header bytes or receive data. `tx_en` is high while waiting for a procedure byte or transmit data. The two are never high together.
- R3: While waiting for CLA, the waiting-time counter is held at zero, and no NULL byte is sent however many ETU ticks arrive.
- R4: While waiting for a procedure byte or transmit data, a NULL byte 0x60 is sent once floor(`wt_etu`/2) ETU ticks have counted since the last restart. The counter then restarts. A host byte in the same cycle takes precedence.
- R5: Every transmitted byte, whether a host byte or a NULL byte, restarts the waiting-time counter. So does every received byte outside the idle state.
- R6: `hdr_len` gives the card-to-reader data length: P3, except that P3=0 gives 256.
- R7: A host byte with `host_pb_rx`=1 switches the block to receiving. A host byte with `host_pb_tx`=1, taken while waiting for the procedure byte, switches the block to transmitting. `host_pb_rx` takes priority.
- R8: In the receive state, each received byte is forwarded on `data_byte` with `data_valid`, one cycle later. The byte that brings the count to P3 carries `data_last`=1, and the block then enters the transmit state for the status word. If `host_pb_rx` is given when P3=0, the block goes straight to the transmit state.
- R9: A host byte with both `host_last` and `host_final` set, and `host_pb_rx`=0, returns the block to waiting for CLA with the receiver enabled.
- R10: A host byte presented while waiting for CLA is consumed and dropped: nothing is transmitted, and `proto_err` pulses for one cycle.
- R11: Host bytes taken while waiting for a procedure byte or transmit data appear on `tx_byte` with `tx_valid`, in order, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A byte has been received from the reader |
| rx_byte | input | 8 | Received byte |
| wt_etu | input | WT_W | Waiting time in ETU |
| etu_tick | input | 1 | One ETU has elapsed |
| host_valid | input | 1 | Host offers a byte |
| host_byte | input | 8 | Host byte to send |
| host_pb_rx | input | 1 | After this byte, receive data from the reader |
| host_pb_tx | input | 1 | After this procedure byte, keep transmitting |
| host_last | input | 1 | Last byte of the host message |
| host_final | input | 1 | The message completes the command |
| host_ready | output | 1 | The host byte is taken this cycle |
| hdr_valid | output | 1 | Header complete strobe |
| hdr_bytes | output | 40 | CLA, INS, P1, P2, P3 (CLA in the MSB) |
| hdr_len | output | 9 | Card-to-reader length derived from P3 |
| data_valid | output | 1 | Received data byte strobe |
| data_byte | output | 8 | Received data byte |
| data_last | output | 1 | Final expected data byte |
| tx_valid | output | 1 | Byte to send to the reader |
| tx_byte | output | 8 | Byte to send |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| proto_err | output | 1 | Host byte dropped while idle |

## Verification
The assertions assume that the UART accepts every `tx_valid` byte without back-pressure. They also assume that the host presents a byte only as a single-cycle offer. The checks on the counter and on direction rely on every exit to the idle state passing through a host byte, which always restarts the timer. The stimulus drives each input for exactly one cycle and never overlaps a received byte with a host byte. It keeps `wt_etu` at 2 or more whenever NULL timing is checked, so the half-time threshold is never zero.

// File: rtl/t0x_pkg.sv
// Shared types and constants for the T=0 transport controller.
// Assumes a five-byte command header and one NULL code.
package t0x_pkg;
    typedef enum logic [2:0] {
        ST_CLA = 3'd0,
        ST_INS = 3'd1,
        ST_P1  = 3'd2,
        ST_P2  = 3'd3,
        ST_P3  = 3'd4,
        ST_PB  = 3'd5,
        ST_RX  = 3'd6,
        ST_TX  = 3'd7
    } t0x_state_e;

    localparam int unsigned HDR_N   = 5;
    localparam logic [7:0]  NULL_PB = 8'h60;
endpackage

// File: rtl/t0x_hdr_capture.sv
// Stores the command header one byte per slot, indexed by the controller
// state, and raises a one-cycle strobe when the last slot is written.
// Assumes cap_idx stays below HDR_N whenever cap_en is high.
module t0x_hdr_capture #(
    parameter int unsigned HDR_N = 5,
    localparam int unsigned IDX_W = $clog2(HDR_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [IDX_W-1:0]     cap_idx,
    input  logic [7:0]           cap_byte,
    output logic [8*HDR_N-1:0]   hdr_bytes,
    output logic [7:0]           last_byte,
    output logic                 hdr_valid
);
    logic [7:0] slot_q [HDR_N];

    for (genvar i = 0; i < HDR_N; i++) begin : g_slot
        // Load one header slot when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= 8'h00;
            else if (cap_en && cap_idx == IDX_W'(i))
                slot_q[i] <= cap_byte;
        end
        assign hdr_bytes[8*(HDR_N-i)-1 -: 8] = slot_q[i];
    end

    assign last_byte = slot_q[HDR_N-1];

    // Pulse once the final header slot has been written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hdr_valid <= 1'b0;
        else
            hdr_valid <= cap_en && cap_idx == IDX_W'(HDR_N-1);
    end
endmodule

// File: rtl/t0x_wait_timer.sv
// Counts ETU ticks since the last restart and flags half the waiting time.
// Held at zero while not running; restart wins over a tick.
// Assumes wt_etu is stable while the timer runs.
module t0x_wait_timer #(
    parameter int unsigned WT_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic            etu_tick,
    input  logic [WT_W-1:0] wt_etu,
    output logic [WT_W-1:0] cnt,
    output logic            half_hit
);
    logic [WT_W-1:0] half;

    assign half     = wt_etu >> 1;
    assign half_hit = run && (half != '0) && (cnt >= half);

    // Advance on ETU ticks, saturating, cleared when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart)
            cnt <= '0;
        else if (etu_tick && cnt != '1)
            cnt <= cnt + WT_W'(1);
    end
endmodule

// File: rtl/t0x_rx_counter.sv
// Counts data bytes received in the current command and flags the byte
// that reaches the expected length. Assumes limit is at least one.
module t0x_rx_counter #(
    parameter int unsigned LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [LEN_W-1:0] limit,
    output logic             at_last
);
    logic [LEN_W-1:0] cnt_q;

    assign at_last = (cnt_q + LEN_W'(1)) == limit;

    // Clear per command, advance on every forwarded data byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + LEN_W'(1);
    end
endmodule

// File: rtl/t0x_xport_ctrl.sv
// Card-side T=0 transport controller. Captures the command header, hands
// it to the host, relays host bytes with direction flags, forwards
// received data and sends NULL bytes at half the waiting time.
// Assumes the UART takes every tx_valid byte and rx_valid lasts one cycle.
module t0x_xport_ctrl
    import t0x_pkg::*;
#(
    parameter int unsigned WT_W = 18,
    localparam int unsigned HDR_W = 8 * HDR_N,
    localparam int unsigned LEN_W = 9,
    localparam int unsigned IDX_W = $clog2(HDR_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic [WT_W-1:0]  wt_etu,
    input  logic             etu_tick,
    input  logic             host_valid,
    input  logic [7:0]       host_byte,
    input  logic             host_pb_rx,
    input  logic             host_pb_tx,
    input  logic             host_last,
    input  logic             host_final,
    output logic             host_ready,
    output logic             hdr_valid,
    output logic [HDR_W-1:0] hdr_bytes,
    output logic [LEN_W-1:0] hdr_len,
    output logic             data_valid,
    output logic [7:0]       data_byte,
    output logic             data_last,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output logic             rx_en,
    output logic             tx_en,
    output logic             proto_err
);
    t0x_state_e      st_q, st_d;
    logic            in_hdr, cap_en, fwd, null_go, half_hit, rx_last, rx_data;
    logic [7:0]      p3;
    logic [WT_W-1:0] tmr_cnt;

    assign in_hdr     = (st_q == ST_CLA) || (st_q == ST_INS) || (st_q == ST_P1)
                     || (st_q == ST_P2) || (st_q == ST_P3);
    assign rx_en      = in_hdr || (st_q == ST_RX);
    assign tx_en      = (st_q == ST_PB) || (st_q == ST_TX);
    assign host_ready = tx_en || (st_q == ST_CLA);
    assign cap_en     = rx_valid && in_hdr;
    assign fwd        = host_valid && tx_en;
    assign null_go    = half_hit && tx_en && !fwd;
    assign rx_data    = rx_valid && (st_q == ST_RX);
    assign hdr_len    = (p3 == 8'h00) ? LEN_W'(256) : LEN_W'(p3);

    t0x_hdr_capture #(.HDR_N(HDR_N)) u_hdr (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
        .cap_idx(st_q[IDX_W-1:0]), .cap_byte(rx_byte),
        .hdr_bytes(hdr_bytes), .last_byte(p3), .hdr_valid(hdr_valid)
    );

    t0x_wait_timer #(.WT_W(WT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(st_q != ST_CLA),
        .restart(rx_valid || fwd || null_go), .etu_tick(etu_tick),
        .wt_etu(wt_etu), .cnt(tmr_cnt), .half_hit(half_hit)
    );

    t0x_rx_counter #(.LEN_W(LEN_W)) u_rxc (
        .clk(clk), .rst_n(rst_n), .clear(rx_valid && st_q == ST_P3),
        .inc(rx_data), .limit(LEN_W'(p3)), .at_last(rx_last)
    );

    // Next-state decision for header, procedure, receive and transmit phases.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLA: if (rx_valid) st_d = ST_INS;
            ST_INS: if (rx_valid) st_d = ST_P1;
            ST_P1:  if (rx_valid) st_d = ST_P2;
            ST_P2:  if (rx_valid) st_d = ST_P3;
            ST_P3:  if (rx_valid) st_d = ST_PB;
            ST_RX:  if (rx_valid && rx_last) st_d = ST_TX;
            ST_PB, ST_TX: begin
                if (fwd) begin
                    if (host_pb_rx)
                        st_d = (p3 == 8'h00) ? ST_TX : ST_RX;
                    else if (host_last && host_final)
                        st_d = ST_CLA;
                    else if (st_q == ST_PB && host_pb_tx)
                        st_d = ST_TX;
                end
            end
            default: st_d = ST_CLA;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_CLA;
        else        st_q <= st_d;
    end

    // Registered transmit, data and error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid   <= 1'b0;
            tx_byte    <= 8'h00;
            data_valid <= 1'b0;
            data_byte  <= 8'h00;
            data_last  <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            tx_valid   <= fwd || null_go;
            if (fwd)          tx_byte <= host_byte;
            else if (null_go) tx_byte <= NULL_PB;
            data_valid <= rx_data;
            if (rx_data) begin
                data_byte <= rx_byte;
                data_last <= rx_last;
            end else begin
                data_last <= 1'b0;
            end
            proto_err  <= host_valid && (st_q == ST_CLA);
        end
    end
endmodule

// File: rtl/t0x_xport_checker.sv
// Temporal properties of the transport controller, attached by bind.
// Assumes the internal state and timer count are reachable by name.
module t0x_xport_checker
    import t0x_pkg::*;
#(
    parameter int unsigned WT_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input t0x_state_e      st,
    input logic            host_valid,
    input logic            rx_en,
    input logic            tx_en,
    input logic            tx_valid,
    input logic            hdr_valid,
    input logic            data_valid,
    input logic            data_last,
    input logic            proto_err,
    input logic [WT_W-1:0] tmr_cnt
);
    p_dir_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && tx_en));
    p_hdr_then_pb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (st == ST_PB) && tx_en);
    p_timer_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLA) |-> (tmr_cnt == '0));
    p_drop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLA && host_valid) |=> (proto_err && !tx_valid));
    p_last_to_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_last) |-> (st == ST_TX));
    p_tx_when_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_en));
endmodule

bind t0x_xport_ctrl t0x_xport_checker #(.WT_W(WT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_q), .host_valid(host_valid),
    .rx_en(rx_en), .tx_en(tx_en), .tx_valid(tx_valid), .hdr_valid(hdr_valid),
    .data_valid(data_valid), .data_last(data_last), .proto_err(proto_err),
    .tmr_cnt(tmr_cnt)
);

// File: tb/t0x_xport_ctrl_test.sv
module t0x_xport_ctrl_test;
    localparam int WT_W = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_byte = 8'h00;
    logic [WT_W-1:0] wt_etu = WT_W'(20);
    logic            etu_tick = 1'b0;
    logic            host_valid = 1'b0;
    logic [7:0]      host_byte = 8'h00;
    logic            host_pb_rx = 1'b0, host_pb_tx = 1'b0;
    logic            host_last = 1'b0, host_final = 1'b0;
    logic            host_ready, hdr_valid, data_valid, data_last;
    logic            tx_valid, rx_en, tx_en, proto_err;
    logic [39:0]     hdr_bytes;
    logic [8:0]      hdr_len;
    logic [7:0]      data_byte, tx_byte;

    int n_chk = 0, n_bad = 0, hdr_cnt = 0, err_cnt = 0;
    logic [7:0] txq[$];
    logic [8:0] dq[$];

    always #5 clk = ~clk;

    t0x_xport_ctrl #(.WT_W(WT_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wt_etu(wt_etu), .etu_tick(etu_tick), .host_valid(host_valid),
        .host_byte(host_byte), .host_pb_rx(host_pb_rx), .host_pb_tx(host_pb_tx),
        .host_last(host_last), .host_final(host_final), .host_ready(host_ready),
        .hdr_valid(hdr_valid), .hdr_bytes(hdr_bytes), .hdr_len(hdr_len),
        .data_valid(data_valid), .data_byte(data_byte), .data_last(data_last),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_en(rx_en), .tx_en(tx_en),
        .proto_err(proto_err)
    );

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid)   txq.push_back(tx_byte);
            if (data_valid) dq.push_back({data_last, data_byte});
            if (hdr_valid)  hdr_cnt++;
            if (proto_err)  err_cnt++;
        end
    end

    function automatic logic [8:0] exp_len(input logic [7:0] p3);
        return (p3 == 8'h00) ? 9'd256 : {1'b0, p3};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(posedge clk); #1 rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic send_host(input logic [7:0] b, input logic prx, input logic ptx,
                             input logic lst, input logic fin);
        @(posedge clk); #1 host_valid = 1'b1; host_byte = b;
        host_pb_rx = prx; host_pb_tx = ptx; host_last = lst; host_final = fin;
        @(posedge clk); #1 host_valid = 1'b0; host_pb_rx = 1'b0; host_pb_tx = 1'b0;
        host_last = 1'b0; host_final = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 etu_tick = 1'b1;
            @(posedge clk); #1 etu_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send_hdr(input logic [39:0] h);
        for (int i = 4; i >= 0; i--) send_rx(h[8*i +: 8]);
        idle(1);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [39:0] h;
        logic [7:0]  b;
        int          p3, hc;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        chk("R2 reset rx_en", rx_en, 1);
        chk("R2 reset tx_en", tx_en, 0);
        chk("R2 reset tx_valid", tx_valid, 0);

        // R10: host byte while idle is dropped with an error pulse
        send_host(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(2);
        chk("R10 err pulse", err_cnt, 1);
        chk("R10 nothing sent", txq.size(), 0);
        chk("R10 still idle", rx_en, 1);

        // R3: ticks while idle never yield NULL
        ticks(30);
        idle(2);
        chk("R3 no null in idle", txq.size(), 0);

        for (int it = 0; it < 8; it++) begin
            p3 = 1 + ($urandom % 8);
            h  = {$urandom, 8'h00};
            h[7:0] = 8'(p3);
            hc = hdr_cnt;
            send_hdr(h);
            chk("R1 header strobe", hdr_cnt, hc + 1);
            chk("R1 header bytes", hdr_bytes, h);
            chk("R6 length", hdr_len, exp_len(h[7:0]));
            chk("R2 tx dir after header", {rx_en, tx_en}, 2'b01);
            txq.delete(); dq.delete();
            if (it % 2 == 0) begin
                send_host(h[31:24], 1'b1, 1'b0, 1'b1, 1'b0);
                idle(1);
                chk("R7 receive mode", {rx_en, tx_en}, 2'b10);
                for (int k = 0; k < p3; k++) begin
                    b = 8'($urandom);
                    send_rx(b);
                    idle(1);
                    chk("R8 data forwarded", dq.pop_front(), {(k == p3 - 1) ? 1'b1 : 1'b0, b});
                end
                chk("R8 transmit after data", {rx_en, tx_en}, 2'b01);
                chk("R11 pb sent", txq.pop_front(), h[31:24]);
            end else begin
                send_host(h[31:24], 1'b0, 1'b1, 1'b0, 1'b0);
                idle(1);
                chk("R7 transmit mode", {rx_en, tx_en}, 2'b01);
                chk("R11 pb sent", txq.pop_front(), h[31:24]);
                for (int k = 0; k < p3; k++) begin
                    b = 8'($urandom);
                    send_host(b, 1'b0, 1'b0, 1'b0, 1'b0);
                    idle(1);
                    chk("R11 data byte order", txq.pop_front(), b);
                end
            end
            send_host(8'h90, 1'b0, 1'b0, 1'b0, 1'b0);
            send_host(8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
            idle(1);
            chk("R11 sw1", txq.pop_front(), 8'h90);
            chk("R11 sw2", txq.pop_front(), 8'h00);
            chk("R9 back to idle", {rx_en, tx_en}, 2'b10);
        end

        // R4: NULL at half the waiting time (wt=20 -> 10 ticks)
        txq.delete();
        send_hdr(40'hA0B0C0D0_05);
        ticks(9);
        idle(3);
        chk("R4 no null before half", txq.size(), 0);
        ticks(1);
        idle(2);
        chk("R4 null count", txq.size(), 1);
        if (txq.size() > 0) chk("R4 null value", txq.pop_front(), 8'h60);
        ticks(9);
        idle(2);
        chk("R4 restart after null", txq.size(), 0);
        ticks(1);
        idle(2);
        chk("R4 second null", txq.size(), 1);
        txq.delete();

        // R5: a host byte restarts the counter
        send_host(8'h33, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(8);
        send_host(8'h44, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(9);
        idle(2);
        chk("R5 only host bytes", txq.size(), 2);
        ticks(1);
        idle(2);
        chk("R5 null after restart", txq.size(), 3);
        if (txq.size() == 3) chk("R5 null value", txq[2], 8'h60);
        send_host(8'h6F, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(1);
        chk("R9 idle after final", rx_en, 1);

        // R6/R8: P3 = 0
        send_hdr(40'h00A4000000);
        chk("R6 zero means 256", hdr_len, 9'd256);
        send_host(8'hA4, 1'b1, 1'b0, 1'b1, 1'b0);
        idle(1);
        chk("R8 zero length skips receive", {rx_en, tx_en}, 2'b01);
        send_host(8'h6A, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(1);
        chk("R9 idle after zero-length", {rx_en, tx_en}, 2'b10);

        finish_run();
    end
endmodule